// File: doc/BRIEF.md
# Gated Frequency Counter with Pulse-Injection Readout

This block counts the rising edges of a measured input during a gate window of programmable length, timed in whole system clock cycles. The measured input may toggle faster than the system clock. It does not pass through a synchronizer; it directly clocks a two-stage ripple counter. The low stage acts as a prescaler and is never read. The high stage is read only once the counter has gone quiet.

When the window closes, a sequencer in the system clock domain records the high stage. It then feeds single pulses into the counter's clock path until it sees the high stage step. The number of pulses N gives the prescaler contents as 2^LO_W − N, and the result joins the recorded high value with that low field. At the end of a measurement the counter is cleared, so the next start begins from zero. A controller pulses `start`, waits for `done`, and reads `result`.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, `done` is 0 and `result` is 0.
- R2: A `start` pulse accepted while idle or done clears the counter. The gate then opens for exactly `win_len` system clock cycles, starting one cycle after the clear cycle. Only rising edges of `meas` that arrive while the gate is open are counted; edges after the gate has closed do not change the result.
- R3: `result` is the number of counted edges modulo 2^(HI_W+LO_W). Bits [LO_W-1:0] hold the recovered low field 2^LO_W − N and the upper HI_W bits hold the high stage; with the defaults this is a 16-bit result.
- R4: When the prescaler holds zero at the end of the window, N reaches 2^LO_W (256 by default) and the low field is reported as 0; a window with no edges therefore gives 0.
- R5: The high field is recorded before injection starts, so the step caused by injection never appears in it, even when the high stage wraps from all ones to zero.
- R6: Injected pulses are one system cycle wide with at least three idle cycles between them. So `done` rises no earlier than `win_len + 4·N` cycles after `start` is sampled.
- R7: Once `done` is set, it and `result` hold until the next accepted `start`; a `start` during a measurement is ignored.
- R8: Completing a measurement clears the counter, so back-to-back measurements each report only their own edges.
- R9: With a free-running input of period T ns and a 10 ns system clock, the result is within ±1 of `win_len`·10/T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas | input | 1 | Measured input, counted on rising edges |
| start | input | 1 | One-cycle request to begin a measurement |
| win_len | input | WIN_W | Gate window length in system clock cycles |
| result | output | HI_W+LO_W | Measured edge count |
| done | output | 1 | Measurement complete, result valid |

## Verification
Random bursts are used with edge counts from 1 to 3000 and input periods of 2 to 6 ns. Because the prescaler residues are scattered, they test the 2^LO_W − N recovery for many values of N. Directed counts cover the other cases. Counts of 0, 256 and 0xFF00 leave the prescaler at zero and need the full 256 pulses, and 0xFF00 also wraps the high stage during injection. A count of 255 needs a single pulse, and 70000 checks the wrap of the total count. Extra edges sent after the gate closes show whether the gate really blocks the input, and a free-running input checks that the window length is exact.

// File: rtl/fgc_pkg.sv
`timescale 1ns/1ps
package fgc_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_CLR    = 3'd1,
    S_GATE   = 3'd2,
    S_SETTLE = 3'd3,
    S_CAPT   = 3'd4,
    S_INJ    = 3'd5,
    S_DONE   = 3'd6
  } fgc_state_e;

  // Low field recovered from the number of injected pulses: (2^lo_w - n) mod 2^lo_w
  function automatic int unsigned low_field(input int unsigned pulses, input int unsigned lo_w);
    int unsigned modulus;
    modulus = 32'd1 << lo_w;
    return (modulus - pulses) % modulus;
  endfunction

endpackage

// File: rtl/fgc_core.sv
`timescale 1ns/1ps
// Ripple counter clocked by the gated measured input or by injected pulses.
module fgc_core #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input  logic            meas_i,
  input  logic            gate_i,
  input  logic            inj_i,
  input  logic            clr_i,
  output logic [HI_W-1:0] hi_o,
  output logic            hi_lsb_o
);
  localparam logic [LO_W-1:0] PRE_TOP = {LO_W{1'b1}};

  // gate and inject are registered and never high together, so the OR stays clean
  logic pclk;
  assign pclk = (meas_i & gate_i) | inj_i;

  logic [LO_W-1:0] pre_q;
  logic [HI_W-1:0] hi_q;
  logic            pre_wrap;

  assign pre_wrap = (pre_q == PRE_TOP);

  always_ff @(posedge pclk or posedge clr_i) begin
    if (clr_i) pre_q <= '0;
    else       pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge pclk or posedge clr_i) begin
    if (clr_i)         hi_q <= '0;
    else if (pre_wrap) hi_q <= hi_q + 1'b1;
  end

  assign hi_o     = hi_q;
  assign hi_lsb_o = hi_q[0];
endmodule

// File: rtl/fgc_sync.sv
`timescale 1ns/1ps
module fgc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/fgc_ctrl.sv
`timescale 1ns/1ps
module fgc_ctrl
  import fgc_pkg::*;
#(
  parameter int LO_W   = 8,
  parameter int HI_W   = 8,
  parameter int WIN_W  = 16,
  parameter int SETTLE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [WIN_W-1:0]     win_len_i,
  input  logic [HI_W-1:0]      hi_i,
  input  logic                 hi_tog_i,
  output logic                 gate_o,
  output logic                 inj_o,
  output logic                 clr_o,
  output logic [HI_W+LO_W-1:0] result_o,
  output logic                 done_o
);
  localparam int N_W   = LO_W + 1;
  localparam int RES_W = HI_W + LO_W;
  localparam int SET_W = $clog2(SETTLE + 1);
  localparam logic [N_W-1:0] N_MAX = N_W'(1) << LO_W;

  fgc_state_e       st_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic [SET_W-1:0] set_cnt_q;
  logic [1:0]       ph_q;
  logic [N_W-1:0]   n_q;
  logic [HI_W-1:0]  hi_cap_q;
  logic             tog_ref_q;
  logic             gate_q, inj_q, clr_q;
  logic [RES_W-1:0] res_q;

  // named internal events
  logic           start_ok, inc_seen, pulse_slot, decide, finish;
  logic [N_W-1:0] n_next;

  assign start_ok   = start_i && (st_q == S_IDLE || st_q == S_DONE);
  assign inc_seen   = (hi_tog_i != tog_ref_q);
  assign pulse_slot = (st_q == S_INJ) && (ph_q == 2'd0);
  assign decide     = (st_q == S_INJ) && (ph_q == 2'd3);
  assign n_next     = n_q + 1'b1;
  assign finish     = decide && (inc_seen || n_next == N_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      win_cnt_q <= '0;
      set_cnt_q <= '0;
      ph_q      <= '0;
      n_q       <= '0;
      hi_cap_q  <= '0;
      tog_ref_q <= 1'b0;
      gate_q    <= 1'b0;
      inj_q     <= 1'b0;
      clr_q     <= 1'b0;
      res_q     <= '0;
    end else begin
      clr_q <= 1'b0;
      inj_q <= pulse_slot;
      unique case (st_q)
        S_IDLE, S_DONE: begin
          if (start_ok) begin
            st_q      <= S_CLR;
            clr_q     <= 1'b1;
            win_cnt_q <= win_len_i;
          end
        end
        S_CLR: begin
          if (win_cnt_q == '0) begin
            st_q      <= S_SETTLE;
            set_cnt_q <= SET_W'(SETTLE);
          end else begin
            st_q   <= S_GATE;
            gate_q <= 1'b1;
          end
        end
        S_GATE: begin
          win_cnt_q <= win_cnt_q - 1'b1;
          if (win_cnt_q == WIN_W'(1)) begin
            gate_q    <= 1'b0;
            st_q      <= S_SETTLE;
            set_cnt_q <= SET_W'(SETTLE);
          end
        end
        S_SETTLE: begin
          set_cnt_q <= set_cnt_q - 1'b1;
          if (set_cnt_q <= SET_W'(1)) st_q <= S_CAPT;
        end
        S_CAPT: begin
          hi_cap_q  <= hi_i;
          tog_ref_q <= hi_tog_i;
          n_q       <= '0;
          ph_q      <= '0;
          st_q      <= S_INJ;
        end
        S_INJ: begin
          ph_q <= ph_q + 1'b1;
          if (decide) n_q <= n_next;
          if (finish) begin
            st_q  <= S_DONE;
            clr_q <= 1'b1;
            res_q <= {hi_cap_q, LO_W'(low_field(32'(n_next), LO_W))};
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign gate_o   = gate_q;
  assign inj_o    = inj_q;
  assign clr_o    = clr_q;
  assign result_o = res_q;
  assign done_o   = (st_q == S_DONE);

  // R2: injected pulses never coincide with an open gate
  p_inj_gate_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inj_q |-> !gate_q) else $error("inject while gate open");

  // R2: the gate is only open while the window timer runs
  p_gate_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> (st_q == S_GATE)) else $error("gate outside window");

  // R6: each injected pulse is followed by three idle cycles
  p_pulse_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_q |=> !inj_q ##1 !inj_q ##1 !inj_q) else $error("pulse spacing");

  // R4: pulse count never exceeds 2^LO_W
  p_n_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    n_q <= N_MAX) else $error("pulse count overflow");

  // R5: recorded high field is frozen during injection
  p_hicap_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_INJ && $past(st_q) == S_INJ) |-> $stable(hi_cap_q)) else $error("high field moved");

  // R7: result and done hold until an accepted start
  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> (done_o && $stable(res_q))) else $error("result not held");

  // R8: finishing a measurement clears the counter
  p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> clr_q) else $error("no clear at done");
endmodule

// File: rtl/freq_gate_counter.sv
`timescale 1ns/1ps
module freq_gate_counter #(
  parameter int LO_W   = 8,
  parameter int HI_W   = 8,
  parameter int WIN_W  = 16,
  parameter int SETTLE = 4,
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 meas,
  input  logic                 start,
  input  logic [WIN_W-1:0]     win_len,
  output logic [HI_W+LO_W-1:0] result,
  output logic                 done
);
  logic            gate_w, inj_w, clr_w, core_clr;
  logic [HI_W-1:0] hi_w;
  logic            hi_lsb_w, hi_tog_w;

  assign core_clr = clr_w | ~rst_n;

  fgc_core #(.LO_W(LO_W), .HI_W(HI_W)) u_core (
    .meas_i   (meas),
    .gate_i   (gate_w),
    .inj_i    (inj_w),
    .clr_i    (core_clr),
    .hi_o     (hi_w),
    .hi_lsb_o (hi_lsb_w)
  );

  fgc_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (hi_lsb_w),
    .q_o   (hi_tog_w)
  );

  fgc_ctrl #(.LO_W(LO_W), .HI_W(HI_W), .WIN_W(WIN_W), .SETTLE(SETTLE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .win_len_i (win_len),
    .hi_i      (hi_w),
    .hi_tog_i  (hi_tog_w),
    .gate_o    (gate_w),
    .inj_o     (inj_w),
    .clr_o     (clr_w),
    .result_o  (result),
    .done_o    (done)
  );
endmodule

// File: tb/freq_gate_counter_bench.sv
`timescale 1ns/1ps
module freq_gate_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas = 1'b0;
  logic        start = 1'b0;
  logic [15:0] win_len = '0;
  logic [15:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc_ctr = 0;

  freq_gate_counter u_freq_gate_counter (
    .clk(clk), .rst_n(rst_n), .meas(meas), .start(start),
    .win_len(win_len), .result(result), .done(done)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc_ctr <= cyc_ctr + 1;

  initial begin
    wait (cyc_ctr >= 190000);
    errors = errors + 1;
    $display("FAIL watchdog: act=%0d cycles exp<190000", cyc_ctr);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // expected result: edge count modulo 2^16
  function automatic int exp_result(input int edges);
    return edges & 16'hFFFF;
  endfunction

  // expected number of injected pulses: pulses needed to roll the low byte over
  function automatic int exp_pulses(input int edges);
    int rem;
    rem = edges % 256;
    if (rem == 0) return 256;
    return 256 - rem;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic emit(input int cnt, input real tm);
    for (int i = 0; i < cnt; i++) begin
      meas = 1'b1; #(tm / 2.0);
      meas = 1'b0; #(tm / 2.0);
    end
  endtask

  task automatic kick(input int w, output int t0);
    @(negedge clk);
    win_len = 16'(w);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc_ctr;
  endtask

  task automatic wait_done(input int t0, output int lat);
    while (!done && cyc_ctr < 189000) @(negedge clk);
    lat = cyc_ctr - t0;
  endtask

  // edges: burst size; tm: period; extra: edges after gate close; poke: start during gate
  task automatic run_burst(input int edges, input real tm, input bit extra, input bit poke, input string req);
    int w, t0, lat;
    w = int'((edges * tm) / 10.0) + 8;
    kick(w, t0);
    repeat (2) @(negedge clk);
    fork
      emit(edges, tm);
      begin
        if (poke) begin
          @(negedge clk); start = 1'b1;
          @(negedge clk); start = 1'b0;
        end
      end
    join
    if (extra) begin
      while (cyc_ctr - t0 < w + 3) @(negedge clk);
      emit(40, 3.0);
    end
    wait_done(t0, lat);
    chk(done === 1'b1, req, "done raised", int'(done), 1);
    chk(int'(result) == exp_result(edges), req, "result", int'(result), exp_result(edges));
    chk(lat >= w + 4 * exp_pulses(edges), "R6", "done latency lower bound", lat, w + 4 * exp_pulses(edges));
  endtask

  initial begin
    int t0, lat, w, hold_val, edges, pick;
    real tm;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done === 1'b0, "R1", "done after reset", int'(done), 0);
    chk(result === 16'd0, "R1", "result after reset", int'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4: empty window, prescaler zero, N = 256
    kick(5, t0);
    wait_done(t0, lat);
    chk(int'(result) == 0, "R4", "empty window result", int'(result), 0);
    chk(lat >= 5 + 4 * 256, "R6", "empty window latency", lat, 5 + 4 * 256);

    // R3: single injection pulse
    run_burst(255, 2.0, 1'b0, 1'b0, "R3");
    // R4: low byte zero with nonzero high
    run_burst(256, 2.5, 1'b0, 1'b0, "R4");
    // R5: high stage wraps during injection
    run_burst(16'hFF00, 2.0, 1'b0, 1'b0, "R5");
    // R3: total count wraps modulo 2^16
    run_burst(70000, 2.0, 1'b0, 1'b0, "R3");

    // R7: result holds while done and no start
    hold_val = int'(result);
    repeat (6) @(negedge clk);
    chk(done === 1'b1, "R7", "done held", int'(done), 1);
    chk(int'(result) == hold_val, "R7", "result held", int'(result), hold_val);

    // R7: start during a measurement is ignored
    run_burst(300, 3.0, 1'b0, 1'b1, "R7");
    // R2: edges after the gate closes are blocked
    run_burst(777, 4.0, 1'b1, 1'b0, "R2");
    // R8: back-to-back measurement reports only its own edges
    run_burst(12, 6.0, 1'b0, 1'b0, "R8");

    // random bursts
    for (int k = 0; k < 8; k++) begin
      edges = int'($urandom_range(1, 3000));
      pick = int'($urandom_range(0, 4));
      case (pick)
        0: tm = 2.0;
        1: tm = 2.5;
        2: tm = 3.0;
        3: tm = 4.0;
        default: tm = 6.0;
      endcase
      run_burst(edges, tm, 1'($urandom_range(0, 1)), 1'b0, "R3");
    end

    // R9: free-running input, exact window
    for (int k = 0; k < 3; k++) begin
      int expv, diff;
      w = 200 + 150 * k;
      tm = (k == 0) ? 3.0 : ((k == 1) ? 7.0 : 4.5);
      kick(w, t0);
      #0.7;
      while (cyc_ctr - t0 < w + 2) emit(1, tm);
      wait_done(t0, lat);
      expv = int'((w * 10.0) / tm);
      diff = int'(result) - expv;
      chk(diff >= -1 && diff <= 1, "R9", "free-running count", int'(result), expv);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule